// File: doc/BRIEF.md
# Asynchronous NOR Flash Bank Controller

This block connects a single-cycle internal request bus to one bank of an asynchronous parallel NOR flash device. Its external flash data path is 8 or 16 bits wide. A read drives chip enable and output enable for a programmed number of clocks, then samples the flash data. A write drives chip enable and write enable with the data for a separate programmed number of clocks. After every strobed access, a programmed number of idle clocks must pass before the next access can start.

The bank has one 32-bit configuration and status register. This register holds:
- the bank enable,
- the address window size,
- two access lengths,
- the idle turnaround,
- the device width,
- read lane masking,
- write protection.

Requests that fall outside the window, and requests made with an unsupported width, are not sent to the flash. Writes to a protected bank are not sent either. Instead, each of these completes at once, and it latches a sticky error flag. Software clears an error flag by writing one to that flag's bit.

Top module: `nor_bank_ctrl`

## Requirements
- R1: After reset the register reads 0 (bank disabled), all flash strobes are high, `fl_doe` is low and `ready` is low.
- R2: While bit 19 (bank enable) is 0, a request produces no strobe and no `ready`.
- R3: An accepted read holds `fl_ce_n` and `fl_oe_n` low for (bits 9:5)+1 cycles, beginning in the cycle after the accept edge. `fl_we_n` stays high. In the cycle after the strobes release, `ready` is high for one cycle and `rdata` holds the flash data sampled at the end of the last strobe cycle.
- R4: An accepted write holds `fl_ce_n` and `fl_we_n` low for (bits 15:11)+1 cycles, with `fl_doe` high and the write data on `fl_dout`. `fl_oe_n` stays high. `ready` pulses in the cycle after the release.
- R5: After a strobed access completes, requests are ignored for the next (bits 3:0) cycles. The strobes stay high during that time. A request arriving while an access is in progress is also ignored. The first request after the turnaround is accepted.
- R6: Bits 18:16 select a window of 128 KiB shifted left by the code, for codes 0 to 6. Code 7 rejects every address. A request whose byte address is at or above the window size sets flag bit 24, causes no strobe, and gives `ready` in the next cycle with `rdata` equal to 0.
- R7: When bit 26 (write protect) is 1, a write sets flag bit 25, causes no strobe, and gives `ready` in the next cycle. Reads still proceed normally.
- R8: Flags 24 and 25 stay set until a register write carries a 1 in that flag's bit. Writing 0 to a flag bit leaves the flag unchanged.
- R9: Bits 29:28 select the width. With code 0 (x8), `fl_addr` is the byte address, data uses lane 0 (bits 7:0) and the upper lane reads as 0. With code 1 (x16), `fl_addr` is the byte address shifted right by one. Codes 2 and 3 are treated as out-of-window errors, as in R6.
- R10: When bit 10 is 1, each read data byte whose `be` bit is 0 reads as 0. When bit 10 is 0, the byte enables do not affect read data.
- R11: Only bits 29:28, 26, 19:16, 15:11, 10, 9:5 and 3:0 are writable. All other bits, apart from the two flags, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request pulse |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 24 | Byte address within the bank |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables for read lane masking |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ready |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register and flag contents |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | 24 | Flash address (byte or word) |
| fl_dout | output | 16 | Data driven to flash |
| fl_doe | output | 1 | Drive enable for fl_dout |
| fl_din | input | 16 | Data returned by flash |

## Verification
Take a request accepted at edge k, with an access length of N. Its strobes are due in the N cycles after edges k through k+N-1. Its `ready` and data are due right after edge k+N. A rejected request shows `ready` and its flag just after edge k. The earliest following request that can be accepted is at edge k+N+idle+1. The bench drives inputs and samples outputs on falling edges, and it keeps a cycle index for each access. Its behavioural model predicts the strobe, address, data and ready values for every one of those cycles. To show that the gaps are enforced exactly, it issues extra requests inside the busy window and during the turnaround, and it places the next real request at the earliest legal edge.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int IDCY_LSB  = 0;
  localparam int WST1_LSB  = 5;
  localparam int RBLE_BIT  = 10;
  localparam int WST2_LSB  = 11;
  localparam int WIN_LSB   = 16;
  localparam int EN_BIT    = 19;
  localparam int BERR_BIT  = 24;
  localparam int WPERR_BIT = 25;
  localparam int WP_BIT    = 26;
  localparam int WIDTH_LSB = 28;
  localparam int WST_W     = 5;
  localparam int IDCY_W    = 4;
  localparam logic [31:0] CFG_WMASK = 32'h340F_FFEF;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RD, SQ_WR, SQ_TURN} seq_st_e;

  typedef struct packed {
    logic              en;
    logic [2:0]        win;
    logic [IDCY_W-1:0] idcy;
    logic [WST_W-1:0]  wst1;
    logic [WST_W-1:0]  wst2;
    logic              rble;
    logic              wp;
    logic [1:0]        width;
  } cfg_t;
endpackage

// File: rtl/nbc_cfg_reg.sv
module nbc_cfg_reg
  import nbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        berr_set,
  input  logic        wperr_set,
  output logic [31:0] rdata,
  output cfg_t        cfg
);
  logic [31:0] ctl_q;
  logic        berr_q;
  logic        wperr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      berr_q  <= 1'b0;
      wperr_q <= 1'b0;
    end else begin
      if (wr) ctl_q <= wdata & CFG_WMASK;
      if (berr_set)                    berr_q <= 1'b1;
      else if (wr && wdata[BERR_BIT])  berr_q <= 1'b0;
      if (wperr_set)                   wperr_q <= 1'b1;
      else if (wr && wdata[WPERR_BIT]) wperr_q <= 1'b0;
    end
  end

  assign rdata = ctl_q | (32'(berr_q) << BERR_BIT) | (32'(wperr_q) << WPERR_BIT);

  assign cfg.en    = ctl_q[EN_BIT];
  assign cfg.win   = ctl_q[WIN_LSB +: 3];
  assign cfg.idcy  = ctl_q[IDCY_LSB +: IDCY_W];
  assign cfg.wst1  = ctl_q[WST1_LSB +: WST_W];
  assign cfg.wst2  = ctl_q[WST2_LSB +: WST_W];
  assign cfg.rble  = ctl_q[RBLE_BIT];
  assign cfg.wp    = ctl_q[WP_BIT];
  assign cfg.width = ctl_q[WIDTH_LSB +: 2];

  // R8: flags hold until cleared by a written one
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (berr_q && !(wr && wdata[BERR_BIT])) |=> berr_q);
  p_wpflag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (wperr_q && !(wr && wdata[WPERR_BIT])) |=> wperr_q);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[BERR_BIT] && !berr_set) |=> !rdata[BERR_BIT]);
endmodule

// File: rtl/nbc_window.sv
module nbc_window #(
  parameter int ADDR_W    = 24,
  parameter int BASE_LOG2 = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        code,
  output logic              hit
);
  localparam int CODES = 7;
  logic [7:0] fits;

  for (genvar c = 0; c < 8; c++) begin : g_code
    localparam int LIM = BASE_LOG2 + c;
    if (c >= CODES) begin : g_resv
      assign fits[c] = 1'b0;
    end else if (LIM >= ADDR_W) begin : g_all
      assign fits[c] = 1'b1;
    end else begin : g_cmp
      assign fits[c] = (addr[ADDR_W-1:LIM] == '0);
    end
  end

  assign hit = fits[code];
endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
  import nbc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_rd,
  input  logic              go_wr,
  input  logic              go_err,
  input  logic              x8,
  input  logic              rble,
  input  logic [DATA_W/8-1:0] be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WST_W-1:0]  wst1,
  input  logic [WST_W-1:0]  wst2,
  input  logic [IDCY_W-1:0] idcy,
  input  logic [DATA_W-1:0] fl_din,
  output logic              idle,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dout,
  output logic              fl_doe
);
  localparam int BE_W = DATA_W / 8;

  seq_st_e           st_q;
  logic [WST_W-1:0]  cnt_q;
  logic [IDCY_W-1:0] gap_q;
  logic              x8_q;
  logic [BE_W-1:0]   lane_q;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] masked;

  assign idle = (st_q == SQ_IDLE);

  always_comb begin
    raw = x8_q ? {{(DATA_W-8){1'b0}}, fl_din[7:0]} : fl_din;
    for (int k = 0; k < BE_W; k++)
      masked[8*k +: 8] = lane_q[k] ? raw[8*k +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      x8_q    <= 1'b0;
      lane_q  <= '0;
      ready   <= 1'b0;
      rdata   <= '0;
      fl_ce_n <= 1'b1;
      fl_oe_n <= 1'b1;
      fl_we_n <= 1'b1;
      fl_addr <= '0;
      fl_dout <= '0;
      fl_doe  <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (go_err) begin
            ready <= 1'b1;
            rdata <= '0;
          end else if (go_rd || go_wr) begin
            st_q    <= go_wr ? SQ_WR : SQ_RD;
            cnt_q   <= go_wr ? wst2 : wst1;
            fl_ce_n <= 1'b0;
            fl_oe_n <= ~go_rd;
            fl_we_n <= ~go_wr;
            fl_addr <= x8 ? addr : (addr >> 1);
            fl_dout <= x8 ? {{(DATA_W-8){1'b0}}, wdata[7:0]} : wdata;
            fl_doe  <= go_wr;
            x8_q    <= x8;
            lane_q  <= rble ? be : '1;
          end
        end
        SQ_RD, SQ_WR: begin
          if (cnt_q == '0) begin
            fl_ce_n <= 1'b1;
            fl_oe_n <= 1'b1;
            fl_we_n <= 1'b1;
            fl_doe  <= 1'b0;
            ready   <= 1'b1;
            rdata   <= (st_q == SQ_RD) ? masked : '0;
            if (idcy == '0) begin
              st_q <= SQ_IDLE;
            end else begin
              st_q  <= SQ_TURN;
              gap_q <= idcy - 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_TURN: begin
          if (gap_q == '0) st_q <= SQ_IDLE;
          else             gap_q <= gap_q - 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R3: read and write strobes never overlap
  p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!fl_oe_n && !fl_we_n));
  // R4: a data strobe is always inside chip enable
  p_strobe_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
    (!fl_oe_n || !fl_we_n) |-> !fl_ce_n);
  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  p_release_ready_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_ce_n) |-> ready);
  // R6: rejected requests complete at once with zero data
  p_err_fast_r6: assert property (@(posedge clk) disable iff (rst)
    (idle && go_err) |=> (ready && rdata == '0 && fl_ce_n));
endmodule

// File: rtl/nor_bank_ctrl.sv
module nor_bank_ctrl
  import nbc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int BASE_LOG2 = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] be,
  output logic                ready,
  output logic [DATA_W-1:0]   rdata,
  input  logic                reg_wr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                fl_ce_n,
  output logic                fl_oe_n,
  output logic                fl_we_n,
  output logic [ADDR_W-1:0]   fl_addr,
  output logic [DATA_W-1:0]   fl_dout,
  output logic                fl_doe,
  input  logic [DATA_W-1:0]   fl_din
);
  cfg_t cfg;
  logic seq_idle, win_hit, bad, accept;
  logic berr_set, wperr_set, go_rd, go_wr, go_err;

  assign accept    = req && seq_idle && cfg.en;
  assign bad       = !win_hit || (cfg.width > 2'd1);
  assign berr_set  = accept && bad;
  assign wperr_set = accept && !bad && we && cfg.wp;
  assign go_err    = berr_set || wperr_set;
  assign go_rd     = accept && !bad && !we;
  assign go_wr     = accept && !bad && we && !cfg.wp;

  nbc_cfg_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .berr_set  (berr_set),
    .wperr_set (wperr_set),
    .rdata     (reg_rdata),
    .cfg       (cfg)
  );

  nbc_window #(.ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)) u_win (
    .addr (addr),
    .code (cfg.win),
    .hit  (win_hit)
  );

  nbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go_rd   (go_rd),
    .go_wr   (go_wr),
    .go_err  (go_err),
    .x8      (cfg.width == 2'd0),
    .rble    (cfg.rble),
    .be      (be),
    .addr    (addr),
    .wdata   (wdata),
    .wst1    (cfg.wst1),
    .wst2    (cfg.wst2),
    .idcy    (cfg.idcy),
    .fl_din  (fl_din),
    .idle    (seq_idle),
    .ready   (ready),
    .rdata   (rdata),
    .fl_ce_n (fl_ce_n),
    .fl_oe_n (fl_oe_n),
    .fl_we_n (fl_we_n),
    .fl_addr (fl_addr),
    .fl_dout (fl_dout),
    .fl_doe  (fl_doe)
  );

  // R7: a protected write never reaches the flash
  p_wp_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    wperr_set |=> (fl_we_n && fl_ce_n));
  // R2: an idle disabled bank stays quiet
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && !cfg.en) |=> (fl_ce_n && !ready));
endmodule

// File: tb/tb_nor_bank_ctrl.sv
module tb_nor_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = 2'b11;
  logic        ready;
  logic [15:0] rdata;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_doe;
  logic [23:0] fl_addr;
  logic [15:0] fl_dout, fl_din;

  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic [31:0] cfg_sh = '0;

  always #2 clk = ~clk;

  // flash model: data is a function of the address it sees
  assign fl_din = {fl_addr[7:0] ^ 8'h5A, fl_addr[7:0]};

  nor_bank_ctrl dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata), .be(be),
    .ready(ready), .rdata(rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int en, int win, int idcy, int w1, int w2, int width, int rble, int wp);
    return (32'(en) << 19) | (32'(win) << 16) | 32'(idcy) | (32'(w1) << 5) |
           (32'(w2) << 11) | (32'(width) << 28) | (32'(rble) << 10) | (32'(wp) << 26);
  endfunction

  task automatic set_cfg(input logic [31:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    cfg_sh = v & 32'h340F_FFEF;
  endtask

  // behavioural model of one access, starting and ending on a falling edge
  task automatic access(input bit w, input logic [23:0] a, input logic [15:0] d,
                        input logic [1:0] b, input bit poke);
    int win, idcy, n, width;
    bit bad, wpb;
    longint lim;
    logic [23:0] fa;
    logic [15:0] raw, exp, dexp;
    win   = int'(cfg_sh[18:16]);
    idcy  = int'(cfg_sh[3:0]);
    width = int'(cfg_sh[29:28]);
    lim   = longint'(64'd1 << (17 + win));
    bad   = (win == 7) || (width > 1) || (longint'(a) >= lim);
    wpb   = w && cfg_sh[26];
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    @(negedge clk);
    if (!cfg_sh[19]) begin
      req = 1'b0;
      for (int i = 0; i < 4; i++) begin
        chk(fl_ce_n && !ready, "R2 disabled bank responded", 32'({fl_ce_n, ready}), 32'h2);
        @(negedge clk);
      end
      return;
    end
    if (bad || wpb) begin
      req = 1'b0;
      chk(ready, bad ? "R6 error ready" : "R7 protect ready", 32'(ready), 32'h1);
      chk(fl_ce_n && fl_we_n, bad ? "R6 no strobe" : "R7 no strobe", 32'({fl_ce_n, fl_we_n}), 32'h3);
      if (!w) chk(rdata == 16'h0, "R6 zero data", 32'(rdata), 32'h0);
      if (bad) chk(reg_rdata[24], "R6 bus error flag", 32'(reg_rdata[24]), 32'h1);
      else     chk(reg_rdata[25], "R7 protect flag", 32'(reg_rdata[25]), 32'h1);
      return;
    end
    n    = int'(w ? cfg_sh[15:11] : cfg_sh[9:5]) + 1;
    fa   = (width == 0) ? a : (a >> 1);
    dexp = (width == 0) ? {8'h00, d[7:0]} : d;
    for (int i = 0; i < n; i++) begin
      if (i == 1) req = 1'b0;
      chk(!fl_ce_n && fl_oe_n == w && fl_we_n == !w && !ready,
          w ? "R4 write strobe" : "R3 read strobe",
          32'({fl_ce_n, fl_oe_n, fl_we_n, ready}), 32'({1'b0, w, !w, 1'b0}));
      chk(fl_addr == fa, "R9 flash address", 32'(fl_addr), 32'(fa));
      if (w) chk(fl_doe && fl_dout == dexp, "R4 write data", 32'({fl_doe, fl_dout}), 32'({1'b1, dexp}));
      @(negedge clk);
    end
    req = 1'b0;
    raw = {fa[7:0] ^ 8'h5A, fa[7:0]};
    if (width == 0) raw[15:8] = 8'h00;
    exp = raw;
    if (cfg_sh[10]) begin
      if (!b[0]) exp[7:0]  = 8'h00;
      if (!b[1]) exp[15:8] = 8'h00;
    end
    chk(ready && fl_ce_n && fl_oe_n && fl_we_n && !fl_doe, "R3 release with ready",
        32'({ready, fl_ce_n, fl_oe_n, fl_we_n, fl_doe}), 32'h1E);
    if (!w) chk(rdata == exp, "R3 R9 R10 read data", 32'(rdata), 32'(exp));
    if (poke && idcy > 0) begin
      req = 1'b1; we = 1'b0; addr = '0;
    end
    for (int j = 1; j <= idcy; j++) begin
      @(negedge clk);
      req = 1'b0;
      chk(fl_ce_n && fl_oe_n && fl_we_n && !ready, "R5 turnaround quiet",
          32'({fl_ce_n, fl_oe_n, fl_we_n, ready}), 32'hE);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 32'h0, "R1 register reset", reg_rdata, 32'h0);
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_doe && !ready, "R1 strobes reset",
        32'({fl_ce_n, fl_oe_n, fl_we_n, fl_doe, ready}), 32'h1C);

    access(1'b0, 24'h000010, 16'h0, 2'b11, 1'b0);               // R2

    set_cfg(32'hFFFF_FFFF);
    chk(reg_rdata == 32'h340F_FFEF, "R11 writable bits", reg_rdata, 32'h340F_FFEF);

    set_cfg(mk(1, 6, 1, 7, 7, 1, 0, 0));
    chk(reg_rdata == mk(1, 6, 1, 7, 7, 1, 0, 0), "R11 readback", reg_rdata, mk(1, 6, 1, 7, 7, 1, 0, 0));
    access(1'b0, 24'h000100, 16'h0, 2'b11, 1'b1);               // R3 R5
    access(1'b0, 24'h7FFFFE, 16'h0, 2'b11, 1'b0);               // R6 top of 8M
    access(1'b1, 24'h000200, 16'hBEEF, 2'b11, 1'b1);            // R4 R5

    set_cfg(mk(1, 6, 0, 0, 0, 1, 0, 0));
    access(1'b0, 24'h000044, 16'h0, 2'b11, 1'b0);
    access(1'b1, 24'h000046, 16'h1234, 2'b11, 1'b0);
    access(1'b0, 24'h000048, 16'h0, 2'b11, 1'b1);

    set_cfg(mk(1, 6, 3, 2, 4, 1, 1, 0));                        // R10
    access(1'b0, 24'h000A0C, 16'h0, 2'b01, 1'b1);
    access(1'b0, 24'h000A0E, 16'h0, 2'b10, 1'b0);
    access(1'b1, 24'h000A10, 16'hC3C3, 2'b00, 1'b0);
    set_cfg(mk(1, 6, 3, 2, 4, 1, 0, 0));
    access(1'b0, 24'h000A12, 16'h0, 2'b00, 1'b0);               // R10 lanes ignored

    set_cfg(mk(1, 6, 2, 3, 1, 0, 0, 0));                        // R9 x8
    access(1'b0, 24'h123457, 16'h0, 2'b11, 1'b0);
    access(1'b1, 24'h000031, 16'hABCD, 2'b11, 1'b1);
    set_cfg(mk(1, 6, 2, 3, 1, 0, 1, 0));
    access(1'b0, 24'h000077, 16'h0, 2'b10, 1'b0);

    set_cfg(mk(1, 0, 1, 1, 1, 1, 0, 0));                        // R6 128K
    access(1'b0, 24'h01FFFE, 16'h0, 2'b11, 1'b0);
    access(1'b0, 24'h020000, 16'h0, 2'b11, 1'b0);
    access(1'b0, 24'h000010, 16'h0, 2'b11, 1'b0);
    chk(reg_rdata[24], "R8 flag sticky after good access", 32'(reg_rdata[24]), 32'h1);
    set_cfg(cfg_sh);
    chk(reg_rdata[24], "R8 zero write keeps flag", 32'(reg_rdata[24]), 32'h1);
    set_cfg(cfg_sh | 32'h0100_0000);
    chk(!reg_rdata[24], "R8 one write clears flag", 32'(reg_rdata[24]), 32'h0);

    set_cfg(mk(1, 7, 1, 1, 1, 1, 0, 0));                        // R6 code 7
    access(1'b0, 24'h000000, 16'h0, 2'b11, 1'b0);
    set_cfg(mk(1, 6, 1, 1, 1, 2, 0, 0) | 32'h0100_0000);        // R9 width 2
    chk(!reg_rdata[24], "R8 clear before width test", 32'(reg_rdata[24]), 32'h0);
    access(1'b0, 24'h000000, 16'h0, 2'b11, 1'b0);

    set_cfg(mk(1, 6, 1, 2, 2, 1, 0, 1));                        // R7
    access(1'b1, 24'h000010, 16'h5555, 2'b11, 1'b0);
    access(1'b0, 24'h000010, 16'h0, 2'b11, 1'b0);
    chk(reg_rdata[25], "R8 protect flag sticky", 32'(reg_rdata[25]), 32'h1);
    set_cfg(cfg_sh | 32'h0200_0000);
    chk(!reg_rdata[25], "R8 protect flag cleared", 32'(reg_rdata[25]), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule